// File: doc/BRIEF.md
# Split Register File with Per-Write Subfile Steering

This block is a multiported register file built as two subfiles, A and B. Both subfiles share the same register-number space and the same size. Every write port reaches both of them, but the read ports are divided into two fixed groups. Group A reads only from subfile A, and group B reads only from subfile B. This halves the read fan-out of each storage array.

Each write port has a 2-bit destination field, which lets the two halves hold different values under the same register number. A value that both read groups need is written to both subfiles. A mode input restores mirrored behaviour: in that mode every real write lands in both halves, and software cannot see the split.

Writes commit on the rising clock edge. Reads are combinational and forward a same-cycle write to the same subfile and register. When two write ports hit the same register in the same subfile in one cycle, the higher-numbered port wins. A synchronous reset clears both subfiles.

Top module: `dualrf_top`

## Requirements
- R1: While `rst` is high at a rising edge, every register in both subfiles becomes zero. With no writes pending, every read port then returns zero.
- R2: A destination field of 2'b01 in split mode writes subfile A only. Subfile B keeps its previous value for that register.
- R3: A destination field of 2'b10 in split mode writes subfile B only. Subfile A keeps its previous value for that register.
- R4: A destination field of 2'b11 writes the same value into that register of both subfiles.
- R5: A destination field of 2'b00 writes nothing, whatever the address and data on that port.
- R6: With `mirror_mode` high, any nonzero destination field (01, 10 or 11) writes both subfiles. A field of 00 still writes nothing.
- R7: In split mode one register number can hold two different values at once. Each read port of group A returns the subfile A value, and each read port of group B returns the subfile B value.
- R8: When several write ports update the same register of the same subfile in one cycle, the highest-numbered of them determines the stored value. Ports that update the same register in different subfiles all take effect.
- R9: A read port whose address matches a write to its own subfile in the current cycle returns the data that will be committed (the winning port's data). A write that goes only to the other subfile is not forwarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset, clears both subfiles |
| mirror_mode | input | 1 | 1: every nonzero destination writes both subfiles |
| wr_tgt | input | 2*NWP | Per-port destination field, port p at bits [2p+1:2p] |
| wr_addr | input | NWP*AW | Per-port register number |
| wr_data | input | NWP*DW | Per-port write data |
| rd_addr_a | input | NRP*AW | Register numbers for read group A |
| rd_data_a | output | NRP*DW | Read data of group A, from subfile A |
| rd_addr_b | input | NRP*AW | Register numbers for read group B |
| rd_data_b | output | NRP*DW | Read data of group B, from subfile B |

## Verification
Three events can meet in one cycle: a read of a register, a write to that same register, and a second write port aiming at that register. The same-cycle conflict arises in two ways:
- between write ports that name one subfile and register;
- between a write and a read that addresses the register being written.

The bench drives both cases in a single cycle. It has two high-numbered ports target one register in subfile B while a lower port writes subfile A. It then samples the read outputs before the clock edge and expects the winning port's data on group B. Group A must keep its old value, because only B was written. After the edge, the bench sweeps every register through every read port and compares against a model built from the priority rule.

// File: rtl/dualrf_pkg.sv
package dualrf_pkg;

    // Default geometry of the register file
    localparam int RF_REGS   = 32;
    localparam int RF_DW     = 64;
    localparam int RF_WPORTS = 4;
    localparam int RF_RPORTS = 4;   // read ports per group

    // Destination field of a write port
    typedef enum logic [1:0] {
        TGT_NONE = 2'b00,
        TGT_A    = 2'b01,
        TGT_B    = 2'b10,
        TGT_BOTH = 2'b11
    } tgt_e;

    // Subfile indices
    localparam int SUB_A = 0;
    localparam int SUB_B = 1;
    localparam int NSUB  = 2;

    // Resolve the destination actually used, given the mode
    function automatic tgt_e resolve_tgt(input logic [1:0] raw, input logic mirror);
        tgt_e t;
        t = tgt_e'(raw);
        if (mirror && t != TGT_NONE)
            return TGT_BOTH;
        return t;
    endfunction

endpackage

// File: rtl/dualrf_steer.sv
module dualrf_steer
    import dualrf_pkg::*;
#(
    parameter int NWP = RF_WPORTS
)(
    input  logic             rst,
    input  logic             mirror_mode,
    input  logic [2*NWP-1:0] wr_tgt,
    output logic [NWP-1:0]   en_a,
    output logic [NWP-1:0]   en_b
);

    // One steering slice per write port
    for (genvar p = 0; p < NWP; p++) begin : g_port
        tgt_e eff;
        always_comb begin
            eff     = resolve_tgt(wr_tgt[2*p +: 2], mirror_mode);
            en_a[p] = !rst && (eff == TGT_A || eff == TGT_BOTH);
            en_b[p] = !rst && (eff == TGT_B || eff == TGT_BOTH);
        end
    end

endmodule

// File: rtl/dualrf_bank.sv
module dualrf_bank
    import dualrf_pkg::*;
#(
    parameter int NREG = RF_REGS,
    parameter int DW   = RF_DW,
    parameter int NWP  = RF_WPORTS,
    parameter int NRP  = RF_RPORTS,
    localparam int AW  = $clog2(NREG)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [NWP-1:0]    wen,
    input  logic [NWP*AW-1:0] waddr,
    input  logic [NWP*DW-1:0] wdata,
    input  logic [NRP*AW-1:0] raddr,
    output logic [NRP*DW-1:0] rdata
);

    logic [DW-1:0] mem [NREG];

    // Ascending port order: a later (higher) port overrides an earlier one
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NREG; r++)
                mem[r] <= '0;
        end else begin
            for (int p = 0; p < NWP; p++)
                if (wen[p])
                    mem[waddr[p*AW +: AW]] <= wdata[p*DW +: DW];
        end
    end

    // Read ports with write-through forwarding, same priority order
    for (genvar r = 0; r < NRP; r++) begin : g_rd
        logic [AW-1:0] ra;
        logic [DW-1:0] q;
        always_comb begin
            ra = raddr[r*AW +: AW];
            q  = mem[ra];
            for (int p = 0; p < NWP; p++)
                if (wen[p] && waddr[p*AW +: AW] == ra)
                    q = wdata[p*DW +: DW];
        end
        assign rdata[r*DW +: DW] = q;
    end

endmodule

// File: rtl/dualrf_top.sv
module dualrf_top
    import dualrf_pkg::*;
#(
    parameter int NREG = RF_REGS,
    parameter int DW   = RF_DW,
    parameter int NWP  = RF_WPORTS,
    parameter int NRP  = RF_RPORTS,
    localparam int AW  = $clog2(NREG)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              mirror_mode,
    input  logic [2*NWP-1:0]  wr_tgt,
    input  logic [NWP*AW-1:0] wr_addr,
    input  logic [NWP*DW-1:0] wr_data,
    input  logic [NRP*AW-1:0] rd_addr_a,
    output logic [NRP*DW-1:0] rd_data_a,
    input  logic [NRP*AW-1:0] rd_addr_b,
    output logic [NRP*DW-1:0] rd_data_b
);

    logic [NWP-1:0]    en_a, en_b;
    logic [NWP-1:0]    en_sub    [NSUB];
    logic [NRP*AW-1:0] raddr_sub [NSUB];
    logic [NRP*DW-1:0] rdata_sub [NSUB];

    dualrf_steer #(.NWP(NWP)) u_steer (
        .rst         (rst),
        .mirror_mode (mirror_mode),
        .wr_tgt      (wr_tgt),
        .en_a        (en_a),
        .en_b        (en_b)
    );

    assign en_sub[SUB_A]    = en_a;
    assign en_sub[SUB_B]    = en_b;
    assign raddr_sub[SUB_A] = rd_addr_a;
    assign raddr_sub[SUB_B] = rd_addr_b;

    for (genvar s = 0; s < NSUB; s++) begin : g_sub
        dualrf_bank #(
            .NREG (NREG),
            .DW   (DW),
            .NWP  (NWP),
            .NRP  (NRP)
        ) u_bank (
            .clk   (clk),
            .rst   (rst),
            .wen   (en_sub[s]),
            .waddr (wr_addr),
            .wdata (wr_data),
            .raddr (raddr_sub[s]),
            .rdata (rdata_sub[s])
        );
    end

    assign rd_data_a = rdata_sub[SUB_A];
    assign rd_data_b = rdata_sub[SUB_B];

endmodule

// File: rtl/dualrf_chk.sv
module dualrf_chk #(
    parameter int NREG = 32,
    parameter int DW   = 64,
    parameter int NWP  = 4,
    parameter int NRP  = 4,
    localparam int AW  = $clog2(NREG),
    localparam int L   = NWP - 1
)(
    input logic              clk,
    input logic              rst,
    input logic              mirror_mode,
    input logic [2*NWP-1:0]  wr_tgt,
    input logic [NWP*AW-1:0] wr_addr,
    input logic [NWP*DW-1:0] wr_data,
    input logic [NRP*AW-1:0] rd_addr_a,
    input logic [NRP*DW-1:0] rd_data_a,
    input logic [NRP*AW-1:0] rd_addr_b,
    input logic [NRP*DW-1:0] rd_data_b
);

    logic          rst_q;
    logic          lo_any, hi_any;
    logic          lo_any_q, hi_any_q, idle_q, mirror_q;
    logic [1:0]    top_tgt;
    logic [AW-1:0] top_addr;
    logic [DW-1:0] top_data;

    always_comb begin
        lo_any = 1'b0;
        hi_any = 1'b0;
        for (int p = 0; p < NWP; p++) begin
            lo_any = lo_any | wr_tgt[2*p];
            hi_any = hi_any | wr_tgt[2*p+1];
        end
    end

    assign top_tgt  = wr_tgt[2*L +: 2];
    assign top_addr = wr_addr[L*AW +: AW];
    assign top_data = wr_data[L*DW +: DW];

    always_ff @(posedge clk) begin
        rst_q    <= rst;
        lo_any_q <= lo_any;
        hi_any_q <= hi_any;
        idle_q   <= (wr_tgt == '0);
        mirror_q <= mirror_mode;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rst_q && wr_tgt == '0) |-> (rd_data_a == '0 && rd_data_b == '0)); // R1

    AST_A_WRITE_SPARES_B: assert property (@(posedge clk) disable iff (rst)
        (!rst_q && !mirror_q && !hi_any_q && wr_tgt == '0 && $stable(rd_addr_b))
            |-> $stable(rd_data_b)); // R2

    AST_B_WRITE_SPARES_A: assert property (@(posedge clk) disable iff (rst)
        (!rst_q && !mirror_q && !lo_any_q && wr_tgt == '0 && $stable(rd_addr_a))
            |-> $stable(rd_data_a)); // R3

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!rst_q && idle_q && wr_tgt == '0 && $stable(rd_addr_a) && $stable(rd_addr_b))
            |-> ($stable(rd_data_a) && $stable(rd_data_b))); // R5

    AST_MIRROR_BOTH: assert property (@(posedge clk) disable iff (rst)
        (mirror_mode && top_tgt != 2'b00 &&
         rd_addr_a[AW-1:0] == top_addr && rd_addr_b[AW-1:0] == top_addr)
            |-> (rd_data_a[DW-1:0] == top_data && rd_data_b[DW-1:0] == top_data)); // R6

    AST_FORWARD_TOP_PORT: assert property (@(posedge clk) disable iff (rst)
        (!mirror_mode && top_tgt == 2'b10 && rd_addr_b[AW-1:0] == top_addr)
            |-> (rd_data_b[DW-1:0] == top_data)); // R9

endmodule

bind dualrf_top dualrf_chk #(
    .NREG (NREG),
    .DW   (DW),
    .NWP  (NWP),
    .NRP  (NRP)
) u_chk (.*);

// File: tb/sim_dualrf_top.sv
module sim_dualrf_top;

    localparam int NREG = 32;
    localparam int DW   = 64;
    localparam int NWP  = 4;
    localparam int NRP  = 4;
    localparam int AW   = $clog2(NREG);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              mirror_mode = 1'b0;
    logic [2*NWP-1:0]  wr_tgt = '0;
    logic [NWP*AW-1:0] wr_addr = '0;
    logic [NWP*DW-1:0] wr_data = '0;
    logic [NRP*AW-1:0] rd_addr_a = '0;
    logic [NRP*AW-1:0] rd_addr_b = '0;
    logic [NRP*DW-1:0] rd_data_a, rd_data_b;

    always #5 clk = ~clk;

    dualrf_top #(.NREG(NREG), .DW(DW), .NWP(NWP), .NRP(NRP)) u0 (
        .clk(clk), .rst(rst), .mirror_mode(mirror_mode),
        .wr_tgt(wr_tgt), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b)
    );

    logic [DW-1:0] exp_a [NREG];
    logic [DW-1:0] exp_b [NREG];
    logic [1:0]    bt [NWP];
    logic [AW-1:0] ba [NWP];
    logic [DW-1:0] bd [NWP];
    int checks = 0, failures = 0;
    bit done = 1'b0;

    function automatic logic [DW-1:0] pat(input int sub, input int r, input int seed);
        return {32'(seed * 4096 + sub * 256 + r), 32'(r) * 32'h0101_0101} ^ 64'hA5A5_0000_0000_5A5A;
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_ports();
        for (int p = 0; p < NWP; p++) begin
            bt[p] = 2'b00; ba[p] = '0; bd[p] = '0;
        end
    endtask

    task automatic drive_w();
        @(negedge clk);
        for (int p = 0; p < NWP; p++) begin
            wr_tgt[2*p +: 2]   = bt[p];
            wr_addr[p*AW +: AW] = ba[p];
            wr_data[p*DW +: DW] = bd[p];
        end
    endtask

    // Commit at the edge and update the model in port order (higher wins)
    task automatic finish_w();
        @(posedge clk);
        for (int p = 0; p < NWP; p++) begin
            logic [1:0] eff;
            eff = (mirror_mode && bt[p] != 2'b00) ? 2'b11 : bt[p];
            if (eff[0]) exp_a[ba[p]] = bd[p];
            if (eff[1]) exp_b[ba[p]] = bd[p];
        end
        #1;
        wr_tgt = '0;
    endtask

    task automatic check_all(input string req);
        wr_tgt = '0;
        for (int r = 0; r < NREG; r++) begin
            for (int k = 0; k < NRP; k++) begin
                rd_addr_a[k*AW +: AW] = AW'((r + k) % NREG);
                rd_addr_b[k*AW +: AW] = AW'((r + 3 * k) % NREG);
            end
            #1;
            for (int k = 0; k < NRP; k++) begin
                chk(req, rd_data_a[k*DW +: DW], exp_a[(r + k) % NREG]);
                chk(req, rd_data_b[k*DW +: DW], exp_b[(r + 3 * k) % NREG]);
            end
        end
    endtask

    task automatic sweep(input logic [1:0] tgt, input int lo, input int hi, input int seed);
        for (int base = lo; base < hi; base += NWP) begin
            for (int p = 0; p < NWP; p++) begin
                bt[p] = tgt;
                ba[p] = AW'(base + p);
                bd[p] = pat(p, base + p, seed);
            end
            drive_w();
            finish_w();
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int r = 0; r < NREG; r++) begin
            exp_a[r] = '0;
            exp_b[r] = '0;
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        clear_ports();
        do_reset();
        check_all("R1 reset state");

        // R2: subfile A only
        sweep(2'b01, 0, NREG, 1);
        check_all("R2 A-only writes");

        // R3 / R7: subfile B only, halves now differ per register
        sweep(2'b10, 0, NREG, 2);
        check_all("R3 R7 B-only writes");

        // R4: both subfiles
        sweep(2'b11, 0, 8, 3);
        check_all("R4 both writes");

        // R5: no-write field with live address and data
        sweep(2'b00, 8, 16, 4);
        check_all("R5 null field");

        // R6: mirror mode forces both for any nonzero field
        @(negedge clk);
        mirror_mode = 1'b1;
        sweep(2'b01, 16, 20, 5);
        sweep(2'b10, 20, 24, 6);
        sweep(2'b00, 24, 28, 7);
        @(negedge clk);
        mirror_mode = 1'b0;
        check_all("R6 mirror mode");

        // R8: same register and subfile from all ports
        for (int p = 0; p < NWP; p++) begin
            bt[p] = 2'b01; ba[p] = AW'(30); bd[p] = pat(p, 30, 8);
        end
        drive_w();
        finish_w();
        // R8: same register, different subfiles
        bt[0] = 2'b01; ba[0] = AW'(31); bd[0] = pat(0, 31, 9);
        bt[1] = 2'b10; ba[1] = AW'(31); bd[1] = pat(1, 31, 9);
        bt[2] = 2'b11; ba[2] = AW'(29); bd[2] = pat(2, 29, 9);
        bt[3] = 2'b01; ba[3] = AW'(29); bd[3] = pat(3, 29, 9);
        drive_w();
        finish_w();
        check_all("R8 port priority");
        chk("R8 highest port wins", exp_a[30], pat(3, 30, 8));

        // R9: same-cycle forwarding, two ports aim at B reg 5
        bt[0] = 2'b01; ba[0] = AW'(6); bd[0] = pat(0, 6, 10);
        bt[1] = 2'b00; ba[1] = AW'(5); bd[1] = pat(1, 5, 10);
        bt[2] = 2'b10; ba[2] = AW'(5); bd[2] = pat(2, 5, 10);
        bt[3] = 2'b10; ba[3] = AW'(5); bd[3] = pat(3, 5, 10);
        drive_w();
        rd_addr_b[0 +: AW]  = AW'(5);
        rd_addr_a[0 +: AW]  = AW'(5);
        rd_addr_a[AW +: AW] = AW'(6);
        #1;
        chk("R9 forward winner to B", rd_data_b[0 +: DW], pat(3, 5, 10));
        chk("R9 no forward to A", rd_data_a[0 +: DW], exp_a[5]);
        chk("R9 forward to A", rd_data_a[DW +: DW], pat(0, 6, 10));
        finish_w();
        check_all("R9 after commit");

        // R1 again after the file is full of data
        do_reset();
        check_all("R1 second reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule